// File: doc/BRIEF.md
# Two-Strike Watchdog Timer

This block is a watchdog counter that catches software which has stopped running its service loop. While the watchdog is enabled, a counter advances once per clock. Software must restart the counter with a clear strobe before it reaches the selected period. If the period runs out without a clear, that counts as one detected processing error.

The first detected error is not fatal. It raises a non-maskable interrupt request flag and the count starts again. If a second period then runs out with no clear in between, the block drives a system reset pulse. The pulse lasts a fixed number of cycles. When it ends, the watchdog puts itself back in its power-on state. A clear strobe restarts the count and also drops the interrupt flag, so only two missed clears in a row lead to a reset.

A configuration write sets the enable bit and the period select. The list of available periods comes from parameters: a base exponent, an exponent step and the number of choices. With these, one instance running from the main clock can offer 2^16, 2^18 and 2^20 cycles. Another instance running from a slow oscillator can offer every power of two from 2^4 to 2^15.

Top module: `wdt2_top`

## Requirements
- R1: After rst_n is released, nmi_req and sys_rst are 0, wd_enabled is 1 and cur_sel is 0.
- R2: Select value k gives a period of 2^(BASE_LOG2 + STEP_LOG2*k) clock cycles. With BASE_LOG2=4 and STEP_LOG2=1, value k gives 2^(4+k) cycles.
- R3: When the counter is enabled and neither cleared nor configured for P cycles in a row (P is the selected period), nmi_req becomes 1 after the P-th rising edge and the count restarts from zero.
- R4: If a second period expires while nmi_req is 1, sys_rst goes high after that edge and stays high for exactly RST_CYCLES (16) clock cycles.
- R5: On the edge that ends the reset pulse, the block returns to its initial state: wd_enabled=1, cur_sel=0, nmi_req=0 and the counter at zero.
- R6: A kick strobe clears the counter and nmi_req. A kick in the cycle where the period would expire takes priority, so no expiry is detected.
- R7: Every accepted configuration write clears the counter, so changing the select restarts the period from zero.
- R8: A configuration write whose cfg_sel is NUM_PERIODS or larger leaves cur_sel unchanged. Its enable bit is still applied.
- R9: While wd_enabled is 0, the counter stays at zero and neither nmi_req nor sys_rst is raised.
- R10: While sys_rst is high, kick and configuration writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Software clear strobe, one cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable value written by cfg_we |
| cfg_sel | input | SEL_W | Period select written by cfg_we |
| nmi_req | output | 1 | First-detection interrupt request flag |
| sys_rst | output | 1 | System reset pulse |
| wd_enabled | output | 1 | Current enable bit |
| cur_sel | output | SEL_W | Current period select |

## Verification
The bench builds the block with the slow-oscillator parameter set: BASE_LOG2=4, STEP_LOG2=1 and NUM_PERIODS=12, which makes cfg_sel 4 bits wide. With these values the shortest periods are 16, 32 and 64 cycles. That keeps the full two-strike sequence, the 16-cycle reset pulse and the return to the initial state within a few dozen cycles each. The same build also reaches the longest period of 2^15 cycles and the unused select codes 12 to 15. Together these cover both ends of the select range and the rejection of invalid codes.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  // log2 of the period chosen by select index idx
  function automatic int period_log2(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction

  // counter width needed for the longest period
  function automatic int cnt_width(input int base, input int step, input int num);
    return period_log2(base, step, num - 1);
  endfunction
endpackage

// File: rtl/wdt2_period_sel.sv
module wdt2_period_sel #(
  parameter int BASE_LOG2   = 16,
  parameter int STEP_LOG2   = 2,
  parameter int NUM_PERIODS = 3,
  parameter int SEL_W       = 2,
  parameter int CNT_W       = 20
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] term
);
  logic [CNT_W-1:0] term_tab [NUM_PERIODS];

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_term
    localparam int LG = wdt2_pkg::period_log2(BASE_LOG2, STEP_LOG2, g);
    assign term_tab[g] = CNT_W'((64'd1 << LG) - 64'd1);
  end

  always_comb begin
    term = term_tab[0];
    for (int i = 0; i < NUM_PERIODS; i++) begin
      if (int'(sel) == i) term = term_tab[i];
    end
  end
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  // a clear in the expiry cycle wins
  assign expire = run && !clr && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr || !run)       cnt_q <= '0;
    else if (expire)            cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/wdt2_strike_ctrl.sv
module wdt2_strike_ctrl #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic kick_ok,
  output logic nmi_req,
  output logic sys_rst,
  output logic pulse_end
);
  localparam int PW = $clog2(RST_CYCLES) + 1;

  logic          strike_q;
  logic          pulse_q;
  logic [PW-1:0] pcnt_q;

  assign pulse_end = pulse_q && (pcnt_q == PW'(RST_CYCLES - 1));
  assign nmi_req   = strike_q;
  assign sys_rst   = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strike_q <= 1'b0;
      pulse_q  <= 1'b0;
      pcnt_q   <= '0;
    end else if (pulse_q) begin
      if (pulse_end) begin
        pulse_q  <= 1'b0;
        strike_q <= 1'b0;
        pcnt_q   <= '0;
      end else begin
        pcnt_q <= pcnt_q + PW'(1);
      end
    end else if (kick_ok) begin
      strike_q <= 1'b0;
    end else if (expire) begin
      if (strike_q) begin
        pulse_q <= 1'b1;
        pcnt_q  <= '0;
      end else begin
        strike_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top #(
  parameter int BASE_LOG2   = 16,
  parameter int STEP_LOG2   = 2,
  parameter int NUM_PERIODS = 3,
  parameter int RST_CYCLES  = 16,
  parameter int SEL_W       = (NUM_PERIODS > 1) ? $clog2(NUM_PERIODS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kick,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             nmi_req,
  output logic             sys_rst,
  output logic             wd_enabled,
  output logic [SEL_W-1:0] cur_sel
);
  localparam int CNT_W = wdt2_pkg::cnt_width(BASE_LOG2, STEP_LOG2, NUM_PERIODS);

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] term_w;
  logic             expire_w;
  logic             pulse_end_w;
  logic             kick_ok;
  logic             cfg_ok;
  logic             sel_ok;
  logic             cnt_clr;
  logic             run_w;

  // software access is blocked while the reset pulse is out
  assign kick_ok = kick && !sys_rst;
  assign cfg_ok  = cfg_we && !sys_rst;
  assign sel_ok  = cfg_ok && (int'(cfg_sel) < NUM_PERIODS);
  assign cnt_clr = kick_ok || cfg_ok || pulse_end_w;
  assign run_w   = en_q && !sys_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b1;
      sel_q <= '0;
    end else if (pulse_end_w) begin
      en_q  <= 1'b1;
      sel_q <= '0;
    end else if (cfg_ok) begin
      en_q <= cfg_enable;
      if (sel_ok) sel_q <= cfg_sel;
    end
  end

  assign wd_enabled = en_q;
  assign cur_sel    = sel_q;

  wdt2_period_sel #(
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .NUM_PERIODS(NUM_PERIODS),
    .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) u_psel (
    .sel  (sel_q),
    .term (term_w)
  );

  wdt2_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_w),
    .clr    (cnt_clr),
    .term   (term_w),
    .expire (expire_w)
  );

  wdt2_strike_ctrl #(.RST_CYCLES(RST_CYCLES)) u_strike (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (expire_w),
    .kick_ok   (kick_ok),
    .nmi_req   (nmi_req),
    .sys_rst   (sys_rst),
    .pulse_end (pulse_end_w)
  );
endmodule

// File: rtl/wdt2_chk.sv
module wdt2_chk #(
  parameter int NUM_PERIODS = 3,
  parameter int RST_CYCLES  = 16,
  parameter int SEL_W       = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             kick,
  input logic             nmi_req,
  input logic             sys_rst,
  input logic             wd_enabled,
  input logic [SEL_W-1:0] cur_sel,
  input logic             expire,
  input logic             pulse_end
);
  int hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= 0;
    else if (sys_rst) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  // R3
  nmi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(expire));

  // R4
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_len == RST_CYCLES));

  // R4
  rst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> ($past(nmi_req) && $past(expire)));

  // R5
  reinit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (wd_enabled && (cur_sel == '0) && !nmi_req));

  // R6
  kick_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kick && !sys_rst && !pulse_end) |=> !nmi_req);

  // R8
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cur_sel) < NUM_PERIODS);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enabled |-> !expire);

  // R10
  pulse_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |-> !expire);
endmodule

bind wdt2_top wdt2_chk #(
  .NUM_PERIODS(NUM_PERIODS), .RST_CYCLES(RST_CYCLES), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .kick       (kick),
  .nmi_req    (nmi_req),
  .sys_rst    (sys_rst),
  .wd_enabled (wd_enabled),
  .cur_sel    (cur_sel),
  .expire     (expire_w),
  .pulse_end  (pulse_end_w)
);

// File: tb/wdt2_top_tb.sv
module wdt2_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W      = 4;
  localparam int NVEC       = 14;
  localparam int WD_LIMIT   = 150000;

  // columns: select, cycles after write, expected nmi_req, expected sys_rst
  localparam int VEC [NVEC][4] = '{
    '{0, 15, 0, 0}, '{0, 16, 1, 0}, '{0, 31, 1, 0}, '{0, 32, 1, 1},
    '{0, 47, 1, 1}, '{0, 48, 0, 0}, '{1, 31, 0, 0}, '{1, 32, 1, 0},
    '{1, 64, 1, 1}, '{2, 63, 0, 0}, '{2, 64, 1, 0}, '{3, 128, 1, 0},
    '{11, 32767, 0, 0}, '{11, 32768, 1, 0}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             kick = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_enable = 1'b1;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic             nmi_req, sys_rst, wd_enabled;
  logic [SEL_W-1:0] cur_sel;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt2_top #(
    .BASE_LOG2(4), .STEP_LOG2(1), .NUM_PERIODS(12), .RST_CYCLES(16), .SEL_W(SEL_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .kick(kick), .cfg_we(cfg_we),
    .cfg_enable(cfg_enable), .cfg_sel(cfg_sel), .nmi_req(nmi_req),
    .sys_rst(sys_rst), .wd_enabled(wd_enabled), .cur_sel(cur_sel)
  );

  function automatic int period_of(input int s);
    return 16 << s;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg_write(input logic en, input int s);
    cfg_we = 1'b1; cfg_enable = en; cfg_sel = SEL_W'(s);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_kick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 nmi_req", int'(nmi_req), 0);
    check("R1 sys_rst", int'(sys_rst), 0);
    check("R1 wd_enabled", int'(wd_enabled), 1);
    check("R1 cur_sel", int'(cur_sel), 0);

    // R2 R3 R4 R5 vector table
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      cfg_write(1'b1, VEC[v][0]);
      repeat (VEC[v][1]) @(negedge clk);
      check($sformatf("R3 vec%0d nmi_req", v), int'(nmi_req), VEC[v][2]);
      check($sformatf("R4 vec%0d sys_rst", v), int'(sys_rst), VEC[v][3]);
    end

    // R5 state after the pulse
    do_reset();
    cfg_write(1'b1, 1);
    repeat (2 * period_of(1) + 16) @(negedge clk);
    check("R5 wd_enabled", int'(wd_enabled), 1);
    check("R5 cur_sel", int'(cur_sel), 0);
    check("R5 nmi_req", int'(nmi_req), 0);
    repeat (period_of(0)) @(negedge clk);
    check("R5 counter restarted", int'(nmi_req), 1);

    // R6 kick in the expiry cycle wins, then kick clears the flag
    do_reset();
    cfg_write(1'b1, 0);
    repeat (period_of(0) - 1) @(negedge clk);
    do_kick();
    check("R6 kick priority", int'(nmi_req), 0);
    repeat (period_of(0) - 1) @(negedge clk);
    check("R6 no early expiry", int'(nmi_req), 0);
    @(negedge clk);
    check("R6 expiry after kick", int'(nmi_req), 1);
    do_kick();
    check("R6 kick clears nmi", int'(nmi_req), 0);
    repeat (period_of(0)) @(negedge clk);
    check("R6 strike restarted nmi", int'(nmi_req), 1);
    check("R6 strike restarted rst", int'(sys_rst), 0);

    // R7 select change restarts the count
    do_reset();
    cfg_write(1'b1, 0);
    repeat (10) @(negedge clk);
    cfg_write(1'b1, 1);
    repeat (period_of(1) - 1) @(negedge clk);
    check("R7 before new period", int'(nmi_req), 0);
    @(negedge clk);
    check("R7 at new period", int'(nmi_req), 1);

    // R8 out-of-range select ignored
    do_reset();
    cfg_write(1'b1, 2);
    cfg_write(1'b1, 13);
    check("R8 cur_sel kept", int'(cur_sel), 2);
    cfg_write(1'b0, 15);
    check("R8 enable applied", int'(wd_enabled), 0);
    check("R8 cur_sel kept 2", int'(cur_sel), 2);

    // R9 disabled watchdog stays quiet
    do_reset();
    cfg_write(1'b0, 0);
    repeat (100) @(negedge clk);
    check("R9 nmi_req", int'(nmi_req), 0);
    check("R9 sys_rst", int'(sys_rst), 0);
    cfg_write(1'b1, 0);
    repeat (period_of(0)) @(negedge clk);
    check("R9 re-enabled", int'(nmi_req), 1);

    // R10 inputs ignored during the pulse
    do_reset();
    cfg_write(1'b1, 0);
    repeat (2 * period_of(0) + 2) @(negedge clk);
    check("R10 in pulse", int'(sys_rst), 1);
    do_kick();
    check("R10 kick ignored", int'(sys_rst), 1);
    cfg_write(1'b0, 5);
    check("R10 cfg ignored en", int'(wd_enabled), 1);
    check("R10 cfg ignored sel", int'(cur_sel), 0);
    repeat (15) @(negedge clk);
    check("R10 pulse ended", int'(sys_rst), 0);
    check("R10 sel after pulse", int'(cur_sel), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule